// File: doc/BRIEF.md
# SPI Host Interrupt and Error Aggregator

This block sits beside an SPI host engine and turns the engine's error pulses and status levels into two interrupt outputs, one for errors and one for events. Error pulses are collected into a sticky error-status register; a per-cause error mask selects which of them may raise the error line. Engine status levels are masked by a per-cause event mask, and a rising edge of any masked status raises the event line. Each line has its own pending bit, line enable and one-shot test bit.

Software reaches the block through a small synchronous register port: a write strobe, an address, write data, and a read-data output that reflects the addressed register in the same cycle. The same port holds the chip-select index. An index that is out of range is refused and reported as an error.

Top module: `spi_irq_agg`

## Requirements
- R1: After synchronous reset every register reads zero, except the error mask (address 3), which reads 0x1F. Both interrupt outputs are low.
- R2: The register addresses are: 0 line pending, 1 line enable, 2 line test, 3 error mask, 4 error status, 5 event mask, 6 chip-select index. In registers 0, 1 and 2, bit 0 is the error line and bit 1 is the event line. The enable and mask registers read back the value written. Address 7 reads zero and ignores writes.
- R3: A pulse on error input bit k sets error-status bit k on the next clock edge, and the bit stays set. The bits are: 0 command busy, 1 overflow, 2 underflow, 3 command invalid, 4 chip-select index invalid, 5 access invalid.
- R4: The error-status and line-pending registers are write-1-to-clear. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R5: A write to the chip-select index with a value below NUM_CS stores that value. A value of NUM_CS or more leaves the stored index unchanged and sets error-status bit 4.
- R6: The error pending bit is set on the clock edge where the error line is enabled and some error-status bit 0..4 is set with its mask bit. While such a cause remains, clearing the pending bit has no lasting effect. Error-status bit 5 never raises the line.
- R7: The event status inputs are: 0 RX full, 1 TX empty, 2 RX watermark, 3 TX watermark, 4 ready, 5 idle. Each is ANDed with its event-mask bit. A rising edge of any masked status sets the event pending bit on that clock edge if the event line is enabled. A steady high status does not set it again.
- R8: Each interrupt output equals its pending bit ANDed with its line enable. A pending bit does not become set while its line is disabled.
- R9: Writing 1 to a test bit sets the matching pending bit two clock edges after the write, if that line is enabled. The test bit reads 1 for one cycle after the write and then returns to 0 by itself.
- R10: A pending bit stays set until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the addressed register |
| err_pulse_i | input | 6 | Error pulses from the engine, one per error-status bit |
| eng_status_i | input | 6 | Status levels from the engine |
| cs_index_o | output | CS_W | Stored chip-select index |
| irq_err_o | output | 1 | Error interrupt |
| irq_evt_o | output | 1 | Event interrupt |

## Verification
The assertions check several properties on every cycle. The stored chip-select index always stays in range, and a refused index write leaves it unchanged and flags bit 4. Pending and error bits hold until they are cleared. A disabled line never becomes pending. Test bits fall back to zero, and an enabled test pulse raises its line.

Other behaviour can only be shown by the bench's scenarios:
- the edge-only event behaviour under a steady status;
- the error line re-raising while a masked cause remains;
- access-invalid never raising the line;
- the exact cycle on which each output changes.

The bench checks these against a cycle model under random traffic and in directed sequences.

// File: rtl/spi_irq_pkg.sv
`timescale 1ns/1ps
package spi_irq_pkg;
    localparam int NUM_ERR   = 6;
    localparam int NUM_ERREN = 5;
    localparam int NUM_EVT   = 6;
    localparam int NUM_LINES = 2;
    localparam int LINE_ERR  = 0;
    localparam int LINE_EVT  = 1;
    localparam int ERR_CSID_BIT = 4;
    localparam logic [NUM_ERREN-1:0] ERR_MASK_RST = '1;

    typedef enum logic [2:0] {
        A_PEND    = 3'd0,
        A_LINE_EN = 3'd1,
        A_TEST    = 3'd2,
        A_ERR_EN  = 3'd3,
        A_ERR_ST  = 3'd4,
        A_EVT_EN  = 3'd5,
        A_CSID    = 3'd6,
        A_NONE    = 3'd7
    } agg_addr_e;

    function automatic logic [NUM_EVT-1:0] rise_of(input logic [NUM_EVT-1:0] cur,
                                                   input logic [NUM_EVT-1:0] prev);
        return cur & ~prev;
    endfunction
endpackage

// File: rtl/spi_w1c_reg.sv
`timescale 1ns/1ps
module spi_w1c_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= (q_o & ~clr_i) | set_i;
    end

    AST_ERR_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))); // R3
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (|(q_o & ~clr_i)) |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i))); // R4
endmodule

// File: rtl/spi_evt_edge.sv
`timescale 1ns/1ps
module spi_evt_edge
    import spi_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] status_i,
    input  logic [NUM_EVT-1:0] mask_i,
    output logic [NUM_EVT-1:0] rise_o
);
    logic [NUM_EVT-1:0] gated, gated_q;

    assign gated  = status_i & mask_i;
    assign rise_o = rise_of(gated, gated_q);

    always_ff @(posedge clk) begin
        if (rst) gated_q <= '0;
        else     gated_q <= gated;
    end
endmodule

// File: rtl/spi_irq_line.sv
`timescale 1ns/1ps
module spi_irq_line (
    input  logic clk,
    input  logic rst,
    input  logic line_en_i,
    input  logic test_i,
    input  logic cause_i,
    input  logic clr_i,
    output logic pending_o,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (rst) pending_o <= 1'b0;
        else     pending_o <= (pending_o & ~clr_i) | (line_en_i & (test_i | cause_i));
    end

    assign irq_o = pending_o & line_en_i;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pending_o && !clr_i) |=> pending_o); // R10
    AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!pending_o && !line_en_i) |=> !pending_o); // R8
    AST_TEST_RAISES: assert property (@(posedge clk) disable iff (rst)
        (line_en_i && test_i) |=> pending_o); // R9
endmodule

// File: rtl/spi_irq_agg.sv
`timescale 1ns/1ps
module spi_irq_agg
    import spi_irq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DW     = 8,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic [NUM_ERR-1:0] err_pulse_i,
    input  logic [NUM_EVT-1:0] eng_status_i,
    output logic [CS_W-1:0]    cs_index_o,
    output logic               irq_err_o,
    output logic               irq_evt_o
);
    logic [NUM_LINES-1:0] line_en_q, test_q, pending, irq_vec, line_cause, pend_clr;
    logic [NUM_ERREN-1:0] err_mask_q;
    logic [NUM_EVT-1:0]   evt_mask_q, evt_rise;
    logic [NUM_ERR-1:0]   err_stat, err_set, err_clr;
    logic                 wr_pend, wr_en, wr_test, wr_emask, wr_estat, wr_vmask, wr_csid;
    logic                 csid_bad, err_cause;

    assign wr_pend  = reg_we && (reg_addr == A_PEND);
    assign wr_en    = reg_we && (reg_addr == A_LINE_EN);
    assign wr_test  = reg_we && (reg_addr == A_TEST);
    assign wr_emask = reg_we && (reg_addr == A_ERR_EN);
    assign wr_estat = reg_we && (reg_addr == A_ERR_ST);
    assign wr_vmask = reg_we && (reg_addr == A_EVT_EN);
    assign wr_csid  = reg_we && (reg_addr == A_CSID);

    assign csid_bad = wr_csid && (32'(reg_wdata) >= 32'(NUM_CS));

    always_ff @(posedge clk) begin
        if (rst) begin
            line_en_q  <= '0;
            test_q     <= '0;
            err_mask_q <= ERR_MASK_RST;
            evt_mask_q <= '0;
            cs_index_o <= '0;
        end else begin
            test_q <= wr_test ? reg_wdata[NUM_LINES-1:0] : '0;
            if (wr_en)    line_en_q  <= reg_wdata[NUM_LINES-1:0];
            if (wr_emask) err_mask_q <= reg_wdata[NUM_ERREN-1:0];
            if (wr_vmask) evt_mask_q <= reg_wdata[NUM_EVT-1:0];
            if (wr_csid && !csid_bad) cs_index_o <= reg_wdata[CS_W-1:0];
        end
    end

    // error status: engine pulses plus refused chip-select writes
    always_comb begin
        err_set = err_pulse_i;
        err_set[ERR_CSID_BIT] = err_pulse_i[ERR_CSID_BIT] | csid_bad;
    end
    assign err_clr = wr_estat ? reg_wdata[NUM_ERR-1:0] : '0;

    spi_w1c_reg #(.W(NUM_ERR)) u_err_stat (
        .clk(clk), .rst(rst), .set_i(err_set), .clr_i(err_clr), .q_o(err_stat)
    );

    spi_evt_edge u_evt_edge (
        .clk(clk), .rst(rst), .status_i(eng_status_i), .mask_i(evt_mask_q), .rise_o(evt_rise)
    );

    assign err_cause             = |(err_stat[NUM_ERREN-1:0] & err_mask_q);
    assign line_cause[LINE_ERR]  = err_cause;
    assign line_cause[LINE_EVT]  = |evt_rise;
    assign pend_clr              = wr_pend ? reg_wdata[NUM_LINES-1:0] : '0;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        spi_irq_line u_line (
            .clk(clk), .rst(rst),
            .line_en_i(line_en_q[g]), .test_i(test_q[g]), .cause_i(line_cause[g]),
            .clr_i(pend_clr[g]), .pending_o(pending[g]), .irq_o(irq_vec[g])
        );
    end

    assign irq_err_o = irq_vec[LINE_ERR];
    assign irq_evt_o = irq_vec[LINE_EVT];

    always_comb begin
        unique case (agg_addr_e'(reg_addr))
            A_PEND:    reg_rdata = DW'(pending);
            A_LINE_EN: reg_rdata = DW'(line_en_q);
            A_TEST:    reg_rdata = DW'(test_q);
            A_ERR_EN:  reg_rdata = DW'(err_mask_q);
            A_ERR_ST:  reg_rdata = DW'(err_stat);
            A_EVT_EN:  reg_rdata = DW'(evt_mask_q);
            A_CSID:    reg_rdata = DW'(cs_index_o);
            default:   reg_rdata = '0;
        endcase
    end

    AST_CSID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(cs_index_o) < 32'(NUM_CS)); // R5
    AST_CSID_REFUSED: assert property (@(posedge clk) disable iff (rst)
        csid_bad |=> ($stable(cs_index_o) && err_stat[ERR_CSID_BIT])); // R5
    AST_TEST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((|test_q) && !wr_test) |=> (test_q == '0)); // R9
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (irq_err_o |-> line_en_q[LINE_ERR]) and (irq_evt_o |-> line_en_q[LINE_EVT])); // R8
endmodule

// File: tb/spi_irq_agg_tb_top.sv
`timescale 1ns/1ps
module spi_irq_agg_tb_top;
    localparam int NUM_CS = 4;
    localparam int DW     = 8;
    localparam int CS_W   = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [5:0]    err_pulse_i = '0;
    logic [5:0]    eng_status_i = '0;
    logic [CS_W-1:0] cs_index_o;
    logic          irq_err_o, irq_evt_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    // bench model state
    logic [5:0] m_es, m_evten, m_gq;
    logic [4:0] m_een;
    logic [1:0] m_ien, m_test, m_pend;
    logic [CS_W-1:0] m_csid;
    logic [5:0] stat_now = '0;

    always #2 clk = ~clk;

    spi_irq_agg #(.NUM_CS(NUM_CS), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_pulse_i(err_pulse_i), .eng_status_i(eng_status_i),
        .cs_index_o(cs_index_o), .irq_err_o(irq_err_o), .irq_evt_o(irq_evt_o)
    );

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return 8'(m_pend);
            3'd1: return 8'(m_ien);
            3'd2: return 8'(m_test);
            3'd3: return 8'(m_een);
            3'd4: return 8'(m_es);
            3'd5: return 8'(m_evten);
            3'd6: return 8'(m_csid);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_es = '0; m_evten = '0; m_gq = '0; m_een = 5'h1F;
        m_ien = '0; m_test = '0; m_pend = '0; m_csid = '0;
    endtask

    // one clock: drive at negedge, advance model, check after the edge
    task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d,
                       input logic [5:0] e, input logic [5:0] s);
        logic [5:0] gated, rise, clr_es, n_es;
        logic [1:0] clr_p, n_pend;
        logic bad, cause_e;
        reg_we = we; reg_addr = a; reg_wdata = d; err_pulse_i = e; eng_status_i = s;
        stat_now = s;
        gated   = s & m_evten;
        rise    = gated & ~m_gq;
        cause_e = |(m_es[4:0] & m_een);
        bad     = we && a == 3'd6 && d >= 8'(NUM_CS);
        clr_es  = (we && a == 3'd4) ? d[5:0] : 6'd0;
        clr_p   = (we && a == 3'd0) ? d[1:0] : 2'd0;
        n_pend[0] = (m_pend[0] & ~clr_p[0]) | (m_ien[0] & (m_test[0] | cause_e));
        n_pend[1] = (m_pend[1] & ~clr_p[1]) | (m_ien[1] & (m_test[1] | (|rise)));
        n_es = (m_es & ~clr_es) | e | {1'b0, bad, 4'b0};
        @(posedge clk);
        @(negedge clk);
        m_pend = n_pend; m_es = n_es; m_gq = gated;
        m_test = (we && a == 3'd2) ? d[1:0] : 2'd0;
        if (we && a == 3'd1) m_ien = d[1:0];
        if (we && a == 3'd3) m_een = d[4:0];
        if (we && a == 3'd5) m_evten = d[5:0];
        if (we && a == 3'd6 && !bad) m_csid = d[CS_W-1:0];
        chk("R8 irq outputs vs model", {irq_evt_o, irq_err_o}, m_pend & m_ien);
        chk("R2 read data vs model", reg_rdata, model_rd(a));
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 6'd0, stat_now);
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input logic [7:0] exp);
        cyc(1'b0, a, 8'd0, 6'd0, stat_now);
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq after reset", {irq_evt_o, irq_err_o}, 2'b00);
        for (int a = 0; a < 8; a++)
            rd(3'(a), "R1 register reset value", (a == 3) ? 8'h1F : 8'h00);

        // R2 readback
        wr(3'd3, 8'h0A); rd(3'd3, "R2 error mask readback", 8'h0A);
        wr(3'd5, 8'h3F); rd(3'd5, "R2 event mask readback", 8'h3F);
        wr(3'd7, 8'hFF); rd(3'd7, "R2 unused address reads zero", 8'h00);
        wr(3'd3, 8'h1F); wr(3'd5, 8'h00);

        // R5 chip-select index
        wr(3'd6, 8'd2); rd(3'd6, "R5 valid index stored", 8'd2);
        wr(3'd6, 8'd4); rd(3'd6, "R5 bad index refused", 8'd2);
        rd(3'd4, "R5 bad index flags bit4", 8'h10);
        chk("R5 index port", 32'(cs_index_o), 32'd2);
        wr(3'd4, 8'h10); rd(3'd4, "R4 w1c clears bit4", 8'h00);

        // R3 / R4 sticky error status
        cyc(1'b0, 3'd4, 8'd0, 6'h02, stat_now);
        chk("R3 overflow pulse sets bit1", reg_rdata, 8'h02);
        repeat (3) rd(3'd4, "R3 bit stays set", 8'h02);
        wr(3'd4, 8'h01); rd(3'd4, "R4 write of other bit leaves it", 8'h02);
        wr(3'd4, 8'h02); rd(3'd4, "R4 w1c clears bit1", 8'h00);

        // R6 error line
        wr(3'd1, 8'h01);
        cyc(1'b0, 3'd4, 8'd0, 6'h04, stat_now);
        chk("R6 no irq on the pulse edge", 32'(irq_err_o), 32'd0);
        rd(3'd0, "R6 error pending set", 8'h01);
        chk("R6 irq_err high", 32'(irq_err_o), 32'd1);
        wr(3'd0, 8'h01);
        chk("R6 pending re-sets while cause remains", 32'(irq_err_o), 32'd1);
        wr(3'd4, 8'h04); wr(3'd0, 8'h01);
        chk("R10 cleared after cause removed", 32'(irq_err_o), 32'd0);
        cyc(1'b0, 3'd4, 8'd0, 6'h20, stat_now);
        rd(3'd0, "R6 access-invalid does not raise", 8'h00);
        rd(3'd0, "R6 access-invalid still quiet", 8'h00);
        wr(3'd4, 8'h20);

        // R7 event line, edge sensitive
        wr(3'd1, 8'h03); wr(3'd5, 8'h10);
        cyc(1'b0, 3'd0, 8'd0, 6'd0, 6'h10);
        chk("R7 ready edge raises event", 32'(irq_evt_o), 32'd1);
        wr(3'd0, 8'h02);
        chk("R4 w1c clears event pending", 32'(irq_evt_o), 32'd0);
        repeat (3) rd(3'd0, "R7 steady ready does not re-raise", 8'h00);
        cyc(1'b0, 3'd0, 8'd0, 6'd0, 6'h00);
        cyc(1'b0, 3'd0, 8'd0, 6'd0, 6'h10);
        chk("R7 new edge raises again", 32'(irq_evt_o), 32'd1);
        cyc(1'b0, 3'd0, 8'd0, 6'd0, 6'h02);
        rd(3'd0, "R7 masked tx-empty leaves pending as is", 8'h02);

        // R8 line enable gating
        wr(3'd1, 8'h01);
        chk("R8 disabled line output low", 32'(irq_evt_o), 32'd0);
        rd(3'd0, "R10 pending kept while disabled", 8'h02);
        wr(3'd1, 8'h03);
        chk("R8 re-enable shows pending", 32'(irq_evt_o), 32'd1);
        wr(3'd0, 8'h02); wr(3'd1, 8'h00);
        cyc(1'b0, 3'd0, 8'd0, 6'd0, 6'h00);
        cyc(1'b0, 3'd0, 8'd0, 6'd0, 6'h10);
        rd(3'd0, "R8 no pending while disabled", 8'h00);

        // R9 test bits
        wr(3'd1, 8'h03);
        cyc(1'b1, 3'd2, 8'h01, 6'd0, stat_now);
        chk("R9 test bit reads one", reg_rdata, 8'h01);
        chk("R9 not yet pending", 32'(irq_err_o), 32'd0);
        rd(3'd2, "R9 test bit self-clears", 8'h00);
        chk("R9 test raises error line", 32'(irq_err_o), 32'd1);
        wr(3'd0, 8'h03);

        // random traffic checked against the model
        for (int i = 0; i < 4000; i++) begin
            logic we_r;
            logic [5:0] e_r;
            we_r = ($urandom % 3) == 0;
            e_r  = (($urandom % 8) == 0) ? 6'($urandom) : 6'd0;
            if (($urandom % 8) == 0) stat_now = 6'($urandom);
            cyc(we_r, 3'($urandom), 8'($urandom), e_r, stat_now);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule